// File: doc/BRIEF.md
# PHY Management Register Unit

This block connects a host register port to a small emulated PHY register file. The file holds sixteen 16-bit registers: control, status, two identifier words, advertisement and link-partner ability, plus general storage. Software first programs a PHY address and a register address. It then writes transmit data or issues command bits. The unit performs the PHY register access in the same clock cycle, so no serial management timing is involved.

Only one PHY address is served. Any other address reads back all ones, and writes to it are dropped. A `linkUp` input models the cable state. The unit folds that level into the status word and the partner ability word, and reports it as a link-fail flag in the host status register. A write to the control word with its top bit set returns the whole PHY file to its power-up contents.

Top module: `phy_mgmt_unit`

## Requirements
- R1: After reset, PHY reads return 0x1000 at register 0, 0x7848 at register 1 (plus bit 2 when the link is up), 0x2000 at register 2, 0x5C90 at register 3 and 0x01E1 at register 4. Register 5 reads 0x01E1 when the link is up and 0 otherwise, and all other registers read 0. The host address, transmit-data, receive-data and link-fail registers read 0.
- R2: Only PHY address `PHY_ADDR` (default 1) is served. A read command to any other PHY address loads 0xFFFF into receive data, and a write to another address changes no PHY register.
- R3: A PHY write to register 0 with bit 15 set restores every PHY register to its R1 value and does not store the written word.
- R4: PHY registers 1, 2 and 3 are read-only, and writes to them are discarded.
- R5: When `linkUp` rises, status bit 2 becomes 1 and register 5 is ORed with 0x01E1. When it falls, status bit 2 becomes 0 and register 5 is ANDed with 0x01FF. Both changes are visible one cycle later, and other writes to register 5 are kept.
- R6: Host select 0 is the address register. Bits 12:8 hold the PHY register number and bits 4:0 hold the PHY address, and it reads back with all other bits 0.
- R7: A write to host select 2 stores bits 15:0 as transmit data and also writes them to the addressed PHY register. Command bit 2 (host select 1) writes the stored transmit data to the addressed register.
- R8: Command bit 1 loads the addressed register into receive data (host select 3, bits 15:0). It also sets the link-fail flag (host select 4, bit 0) to the inverse of `linkUp`.
- R9: While command bit 0 (scan) is held, the link-fail flag follows the inverse of `linkUp` one cycle later. Without scan and without a read command, the flag holds its value.
- R10: PHY register numbers 16 to 31 read as 0, and writes to them have no effect.
- R11: Host writes to receive data and to the link-fail status are ignored. The command register reads back only the scan bit at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostSel | input | 3 | Host register select: 0 address, 1 command, 2 transmit data, 3 receive data, 4 status |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Combinational read of the selected host register |
| linkUp | input | 1 | Link level fed to the PHY model |

## Verification
The register walk reads every PHY register after reset, including a number beyond the file. This separates the fixed identifiers, the link-dependent status and partner words, and the zero-filled storage. Directed writes compare the three ways of addressing the file:
- the served PHY address,
- a foreign PHY address,
- an out-of-range register number.

A write under the served address that reads back confirms that a foreign-address write was dropped rather than lost in transit. Link toggles made with scan on and with scan off show whether the link-fail flag tracks the link or holds its value. A partner word written with bits outside both masks shows the OR-on-rise and AND-on-fall rules apart from a plain overwrite.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int PHY_DW     = 16;
  localparam int FIELD_W    = 5;
  localparam int IDX_CTRL   = 0;
  localparam int IDX_STAT   = 1;
  localparam int IDX_ID_HI  = 2;
  localparam int IDX_ID_LO  = 3;
  localparam int IDX_ADV    = 4;
  localparam int IDX_PART   = 5;
  localparam logic [PHY_DW-1:0] PART_UP_SET   = 16'h01E1;
  localparam logic [PHY_DW-1:0] PART_DOWN_KEEP = 16'h01FF;
  localparam logic [PHY_DW-1:0] STAT_BASE     = 16'h7848;

  localparam logic [2:0] SEL_ADDR = 3'd0;
  localparam logic [2:0] SEL_CMD  = 3'd1;
  localparam logic [2:0] SEL_TXD  = 3'd2;
  localparam logic [2:0] SEL_RXD  = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  typedef struct packed {
    logic setAddr;
    logic setCmd;
    logic setTx;
    logic phyWr;
    logic wrFromBus;
    logic phyRd;
    logic rdLocal;
  } strobes_t;

  function automatic logic [PHY_DW-1:0] resetWord(input int idx);
    case (idx)
      IDX_CTRL:  return 16'h1000;
      IDX_STAT:  return STAT_BASE;
      IDX_ID_HI: return 16'h2000;
      IDX_ID_LO: return 16'h5C90;
      IDX_ADV:   return 16'h01E1;
      default:   return '0;
    endcase
  endfunction

  function automatic logic isReadOnly(input int idx);
    return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
  endfunction

endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic               hostWrEn,
  input  logic [2:0]         hostSel,
  input  logic [2:0]         cmdBits,
  input  logic [FIELD_W-1:0] curPhyAddr,
  output strobes_t           strb
);

  logic isLocal;
  logic cmdWr;

  always_comb begin
    isLocal        = (curPhyAddr == FIELD_W'(PHY_ADDR));
    cmdWr          = hostWrEn && (hostSel == SEL_CMD);
    strb.setAddr   = hostWrEn && (hostSel == SEL_ADDR);
    strb.setCmd    = cmdWr;
    strb.setTx     = hostWrEn && (hostSel == SEL_TXD);
    strb.wrFromBus = strb.setTx;
    strb.phyWr     = isLocal && (strb.setTx || (cmdWr && cmdBits[2]));
    strb.phyRd     = cmdWr && cmdBits[1];
    strb.rdLocal   = isLocal;
  end

endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int HOST_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strb,
  input  logic [2:0]         hostSel,
  input  logic [HOST_W-1:0]  hostWrData,
  input  logic               linkUp,
  output logic [HOST_W-1:0]  hostRdData,
  output logic [FIELD_W-1:0] phyAddrQ,
  output logic [PHY_DW-1:0]  rxQ,
  output logic               linkFailQ,
  output logic               scanQ,
  output logic               linkSeenQ
);

  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [FIELD_W-1:0] regAddrQ;
  logic [PHY_DW-1:0]  txQ;
  logic [PHY_DW-1:0]  fileQ  [REG_COUNT];
  logic [PHY_DW-1:0]  fileNxt[REG_COUNT];
  logic [PHY_DW-1:0]  wrWord;
  logic               softRst;
  logic               inRange;
  logic               linkChg;

  always_comb begin
    wrWord  = strb.wrFromBus ? hostWrData[PHY_DW-1:0] : txQ;
    inRange = ({1'b0, regAddrQ} < (FIELD_W+1)'(REG_COUNT));
    softRst = strb.phyWr && (regAddrQ == FIELD_W'(IDX_CTRL)) && wrWord[15];
    linkChg = (linkUp != linkSeenQ);
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    if (i == IDX_STAT) begin : g_stat
      always_comb fileNxt[i] = STAT_BASE | {13'd0, linkUp, 2'b00};
    end else if (isReadOnly(i)) begin : g_const
      always_comb fileNxt[i] = resetWord(i);
    end else if (i == IDX_PART) begin : g_part
      logic [PHY_DW-1:0] base;
      always_comb begin
        base = fileQ[i];
        if (strb.phyWr && inRange && regAddrQ == FIELD_W'(i)) base = wrWord;
        if (softRst)
          fileNxt[i] = linkUp ? PART_UP_SET : '0;
        else if (linkChg)
          fileNxt[i] = linkUp ? (base | PART_UP_SET) : (base & PART_DOWN_KEEP);
        else
          fileNxt[i] = base;
      end
    end else begin : g_rw
      always_comb begin
        if (softRst)
          fileNxt[i] = resetWord(i);
        else if (strb.phyWr && inRange && regAddrQ == FIELD_W'(i))
          fileNxt[i] = wrWord;
        else
          fileNxt[i] = fileQ[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        if (i == IDX_STAT)      fileQ[i] <= STAT_BASE | {13'd0, linkUp, 2'b00};
        else if (i == IDX_PART) fileQ[i] <= linkUp ? PART_UP_SET : '0;
        else                    fileQ[i] <= resetWord(i);
      end else begin
        fileQ[i] <= fileNxt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phyAddrQ  <= '0;
      regAddrQ  <= '0;
      txQ       <= '0;
      rxQ       <= '0;
      linkFailQ <= 1'b0;
      scanQ     <= 1'b0;
      linkSeenQ <= linkUp;
    end else begin
      linkSeenQ <= linkUp;
      if (strb.setAddr) begin
        regAddrQ <= hostWrData[8 +: FIELD_W];
        phyAddrQ <= hostWrData[0 +: FIELD_W];
      end
      if (strb.setCmd) scanQ <= hostWrData[0];
      if (strb.setTx)  txQ   <= hostWrData[PHY_DW-1:0];
      if (strb.phyRd) begin
        if (!strb.rdLocal)  rxQ <= '1;
        else if (inRange)   rxQ <= fileNxt[regAddrQ[IDX_W-1:0]];
        else                rxQ <= '0;
      end
      if (strb.phyRd || scanQ) linkFailQ <= ~linkUp;
    end
  end

  always_comb begin
    hostRdData = '0;
    case (hostSel)
      SEL_ADDR: begin
        hostRdData[8 +: FIELD_W] = regAddrQ;
        hostRdData[0 +: FIELD_W] = phyAddrQ;
      end
      SEL_CMD:  hostRdData[0] = scanQ;
      SEL_TXD:  hostRdData[PHY_DW-1:0] = txQ;
      SEL_RXD:  hostRdData[PHY_DW-1:0] = rxQ;
      SEL_STAT: hostRdData[0] = linkFailQ;
      default:  hostRdData = '0;
    endcase
  end

endmodule

// File: rtl/phy_mgmt_unit.sv
module phy_mgmt_unit
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR  = 1,
  parameter int REG_COUNT = 16,
  parameter int HOST_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic [2:0]        hostSel,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [HOST_W-1:0] hostRdData,
  input  logic              linkUp
);

  strobes_t           strb;
  logic [FIELD_W-1:0] phyAddr;
  logic [PHY_DW-1:0]  rxData;
  logic               linkFail;
  logic               scanOn;
  logic               linkSeen;

  phy_mgmt_ctrl #(.PHY_ADDR(PHY_ADDR)) u_ctrl (
    .hostWrEn   (hostWrEn),
    .hostSel    (hostSel),
    .cmdBits    (hostWrData[2:0]),
    .curPhyAddr (phyAddr),
    .strb       (strb)
  );

  phy_mgmt_dp #(.REG_COUNT(REG_COUNT), .HOST_W(HOST_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .hostSel    (hostSel),
    .hostWrData (hostWrData),
    .linkUp     (linkUp),
    .hostRdData (hostRdData),
    .phyAddrQ   (phyAddr),
    .rxQ        (rxData),
    .linkFailQ  (linkFail),
    .scanQ      (scanOn),
    .linkSeenQ  (linkSeen)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int HOST_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               hostWrEn,
  input logic [2:0]         hostSel,
  input logic [HOST_W-1:0]  hostWrData,
  input logic               linkUp,
  input logic [FIELD_W-1:0] phyAddr,
  input logic [PHY_DW-1:0]  rxData,
  input logic               linkFail,
  input logic               scanOn,
  input logic               linkSeen
);

  logic rdCmd;
  assign rdCmd = hostWrEn && (hostSel == SEL_CMD) && hostWrData[1];

  AST_FOREIGN_ONES: assert property (@(posedge clk) disable iff (rst)
    (rdCmd && phyAddr != FIELD_W'(PHY_ADDR)) |=> (rxData == 16'hFFFF)); // R2

  AST_READ_LINKFAIL: assert property (@(posedge clk) disable iff (rst)
    rdCmd |=> (linkFail == !$past(linkUp))); // R8

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rdCmd |=> $stable(rxData)); // R11

  AST_SCAN_TRACK: assert property (@(posedge clk) disable iff (rst)
    scanOn |=> (linkFail == !$past(linkUp))); // R9

  AST_NOSCAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!scanOn && !rdCmd) |=> $stable(linkFail)); // R9

  AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (linkSeen == $past(linkUp))); // R5

endmodule

bind phy_mgmt_unit phy_mgmt_chk #(.PHY_ADDR(PHY_ADDR), .HOST_W(HOST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hostWrEn   (hostWrEn),
  .hostSel    (hostSel),
  .hostWrData (hostWrData),
  .linkUp     (linkUp),
  .phyAddr    (phyAddr),
  .rxData     (rxData),
  .linkFail   (linkFail),
  .scanOn     (scanOn),
  .linkSeen   (linkSeen)
);

// File: tb/test_phy_mgmt_unit.sv
module test_phy_mgmt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {register number, expected read with link up after reset}
  localparam logic [20:0] RD_VEC [NVEC] = '{
    {5'd0,  16'h1000}, {5'd1,  16'h784C}, {5'd2,  16'h2000},
    {5'd3,  16'h5C90}, {5'd4,  16'h01E1}, {5'd5,  16'h01E1},
    {5'd6,  16'h0000}, {5'd15, 16'h0000}, {5'd16, 16'h0000},
    {5'd31, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostSel = 3'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        linkUp = 1'b1;

  int checks = 0;
  int fails  = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_unit i_phy_mgmt_unit (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .linkUp(linkUp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = s; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0;
  endtask

  task automatic hostRead(input logic [2:0] s, output logic [31:0] r);
    hostSel = s;
    #1;
    r = hostRdData;
  endtask

  task automatic phyRead(input logic [4:0] phy, input logic [4:0] rg, output logic [31:0] r);
    hostWrite(3'd0, {19'd0, rg, 3'd0, phy});
    hostWrite(3'd1, 32'h2);
    hostRead(3'd3, r);
  endtask

  task automatic phyWrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    hostWrite(3'd0, {19'd0, rg, 3'd0, phy});
    hostWrite(3'd2, {16'd0, d});
  endtask

  task automatic setLink(input logic l);
    @(negedge clk);
    linkUp = l;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 host-side reset state
    hostRead(3'd0, v); check("R1 addr reset", v, 32'h0);
    hostRead(3'd2, v); check("R1 txdata reset", v, 32'h0);
    hostRead(3'd3, v); check("R1 rxdata reset", v, 32'h0);
    hostRead(3'd4, v); check("R1 linkfail reset", v, 32'h0);

    // R1 R10 table walk over the PHY file
    for (int k = 0; k < NVEC; k++) begin
      phyRead(5'd1, RD_VEC[k][20:16], v);
      check("R1/R10 reset read", v, {16'd0, RD_VEC[k][15:0]});
    end

    // R6 address field placement
    hostWrite(3'd0, 32'hFFFF_FFFF);
    hostRead(3'd0, v); check("R6 addr fields", v, 32'h0000_1F1F);

    // R7 tx write and write-control command
    phyWrite(5'd1, 5'd7, 16'hABCD);
    hostRead(3'd2, v); check("R7 txdata stored", v, 32'h0000_ABCD);
    phyRead(5'd1, 5'd7, v); check("R7 tx write to phy", v, 32'h0000_ABCD);
    hostWrite(3'd0, {19'd0, 5'd8, 3'd0, 5'd1});
    hostWrite(3'd1, 32'h4);
    phyRead(5'd1, 5'd8, v); check("R7 write-control cmd", v, 32'h0000_ABCD);

    // R2 foreign PHY address
    phyWrite(5'd2, 5'd7, 16'h1111);
    phyRead(5'd2, 5'd7, v); check("R2 foreign read", v, 32'h0000_FFFF);
    phyRead(5'd1, 5'd7, v); check("R2 foreign write ignored", v, 32'h0000_ABCD);

    // R4 read-only registers
    phyWrite(5'd1, 5'd1, 16'h0000);
    phyRead(5'd1, 5'd1, v); check("R4 status ro", v, 32'h0000_784C);
    phyWrite(5'd1, 5'd2, 16'h1234);
    phyRead(5'd1, 5'd2, v); check("R4 id ro", v, 32'h0000_2000);

    // R10 out-of-range write
    phyWrite(5'd1, 5'd20, 16'h5555);
    phyRead(5'd1, 5'd20, v); check("R10 high reg", v, 32'h0);

    // R3 soft reset via control bit 15
    phyWrite(5'd1, 5'd4, 16'h0000);
    phyWrite(5'd1, 5'd0, 16'h0100);
    phyRead(5'd1, 5'd0, v); check("R3 control stored", v, 32'h0000_0100);
    phyWrite(5'd1, 5'd0, 16'h8000);
    phyRead(5'd1, 5'd0, v); check("R3 control reset", v, 32'h0000_1000);
    phyRead(5'd1, 5'd4, v); check("R3 adv reset", v, 32'h0000_01E1);
    phyRead(5'd1, 5'd7, v); check("R3 storage reset", v, 32'h0);
    phyRead(5'd1, 5'd5, v); check("R3 partner reset", v, 32'h0000_01E1);

    // R5 link effects
    phyWrite(5'd1, 5'd5, 16'hFFFF);
    phyRead(5'd1, 5'd5, v); check("R5 partner write", v, 32'h0000_FFFF);
    setLink(1'b0);
    phyRead(5'd1, 5'd5, v); check("R5 partner and on fall", v, 32'h0000_01FF);
    phyRead(5'd1, 5'd1, v); check("R5 status down", v, 32'h0000_7848);
    phyWrite(5'd1, 5'd5, 16'h8002);
    setLink(1'b1);
    phyRead(5'd1, 5'd5, v); check("R5 partner or on rise", v, 32'h0000_81E3);
    phyRead(5'd1, 5'd1, v); check("R5 status up", v, 32'h0000_784C);

    // R8 R9 link-fail flag
    setLink(1'b0);
    phyRead(5'd1, 5'd0, v);
    hostRead(3'd4, v); check("R8 linkfail on read", v, 32'h1);
    setLink(1'b1);
    hostRead(3'd4, v); check("R9 hold without scan", v, 32'h1);
    hostWrite(3'd1, 32'h3);
    hostRead(3'd1, v); check("R11 cmd readback", v, 32'h1);
    @(negedge clk);
    hostRead(3'd4, v); check("R9 scan up", v, 32'h0);
    setLink(1'b0);
    hostRead(3'd4, v); check("R9 scan down", v, 32'h1);
    hostWrite(3'd1, 32'h0);
    setLink(1'b1);
    hostRead(3'd4, v); check("R9 scan off hold", v, 32'h1);

    // R11 ignored host writes
    phyRead(5'd1, 5'd3, v);
    hostWrite(3'd3, 32'h1234);
    hostRead(3'd3, v); check("R11 rxdata ro", v, 32'h0000_5C90);
    hostWrite(3'd4, 32'h0);
    hostRead(3'd4, v); check("R11 status ro", v, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule